// File: doc/BRIEF.md
# Compressed-Aware Instruction Prefetch Aligner

This block sits between a processor fetch stage and an instruction bus that only returns whole, aligned 32-bit words. It keeps a small queue of prefetched words ahead of the program counter. From that queue it cuts out the instruction at the current halfword-aligned PC. That instruction is either a 16-bit compressed instruction or a 32-bit one, and a 32-bit instruction may straddle two words. The result goes to a valid/ready output together with its PC and an access-fault flag.

Each queued word keeps the error flag its bus response carried. An instruction is flagged faulting only when one of the halfwords it really uses comes from a faulting word. So a compressed instruction in the upper half of a good word still issues cleanly when the following word faults. A faulting instruction goes out with a zero instruction field. After it, the block stops fetching and stops issuing until the core redirects it.

A redirect empties the queue and discards bus responses that belong to requests made before the redirect. Fetching then restarts at the new PC rounded down to a word boundary.

Top module: `pf_align_top`

## Requirements
- R1: Every bus request address has its two low bits zero. After a restart, successive request addresses step by 4.
- R2: A halfword whose low two bits are not 2'b11 is a compressed instruction, in either half of a word. It issues as {16'h0, halfword} and the PC then advances by 2. When the low two bits are 2'b11 the instruction is 32 bits wide and the PC advances by 4.
- R3: A 32-bit instruction at a PC with bit 1 set is issued as {next word[15:0], current word[31:16]}. It is not presented until both words are buffered.
- R4: Faults are judged per word. An instruction whose PC lies in a faulting word is flagged. A straddling instruction is flagged if either of its two words faulted. A compressed instruction at A-2, taken from a good word, issues unflagged when the word at A faults.
- R5: While the fault flag is set on a valid output, the instruction field is all zeros.
- R6: After a flagged instruction is accepted, no further instruction is offered and no bus request is made until a redirect.
- R7: A redirect empties the buffer, and responses to requests made before it are dropped. The first request after it is at the new PC with its low two bits cleared. When PC bit 1 is set, the first issued instruction starts at the upper halfword.
- R8: A bus request is made only when the buffered words plus the outstanding requests number fewer than DEPTH.
- R9: While valid is high and ready is low, the PC, instruction and fault outputs hold their values.
- R10: During reset no instruction is offered. After reset, fetching starts at RESET_PC rounded down to a word, and issue starts at RESET_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReqValid | output | 1 | Bus read request valid |
| memReqReady | input | 1 | Bus accepts the request |
| memReqAddr | output | ADDR_W | Word-aligned read address |
| memRspValid | input | 1 | Read response valid, in request order |
| memRspData | input | 32 | Read data word |
| memRspErr | input | 1 | Access fault on this word |
| redirValid | input | 1 | Redirect strobe |
| redirPc | input | ADDR_W | New PC (bit 0 ignored) |
| insnValid | output | 1 | Instruction output valid |
| insnReady | input | 1 | Consumer accepts the instruction |
| insnPc | output | ADDR_W | PC of the offered instruction |
| insnData | output | 32 | Instruction, zero-extended if compressed |
| insnFault | output | 1 | Instruction access fault |

## Verification
The bench builds the block with DEPTH = 3 and RESET_PC = 0x102. A depth that is not a power of two exercises wrap-around of the queue pointers. The odd reset PC makes the very first issue skip a lower halfword. A three-cycle bus latency and gaps in request and output readiness keep several responses in flight across every redirect, so stale responses have to be discarded. Faulting words at 0x3000 and 0x4000, with chosen halfwords just below them, bring in the clean A-2 compressed case, the straddle into a faulting word, and exact and mid-word starts inside a faulting word.

// File: rtl/pf_align_pkg.sv
`timescale 1ns/1ps
package pf_align_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic flush;
    logic push;
    logic pop;
    logic advance;
    logic reqFire;
  } pfStrobes_t;

  function automatic logic isWide(input logic [1:0] lowBits);
    return lowBits == 2'b11;
  endfunction
endpackage

// File: rtl/pf_align_dp.sv
`timescale 1ns/1ps
module pf_align_dp
  import pf_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfStrobes_t        strb,
  input  logic [ADDR_W-1:0] redirPc,
  input  logic [WORD_W-1:0] rspData,
  input  logic              rspErr,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              headOk,
  output logic              headFault,
  output logic              popNeed,
  output logic [ADDR_W-1:0] outPc,
  output logic [WORD_W-1:0] outData
);

  logic [WORD_W-1:0] slotData [DEPTH];
  logic [DEPTH-1:0]  slotErr;
  logic [PTR_W-1:0]  rdPtr, wrPtr, rdPtrNext;
  logic [ADDR_W-1:0] pcReg, fetchAddr;
  logic [HALF_W-1:0] loHalf;
  logic              wide;
  logic [WORD_W-1:0] rawData;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign rdPtrNext = stepPtr(rdPtr);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.push && wrPtr == PTR_W'(i)) begin
        slotData[i] <= rspData;
        slotErr[i]  <= rspErr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= stepPtr(wrPtr);
      if (strb.pop) rdPtr <= rdPtrNext;
      count <= count + CNT_W'(strb.push) - CNT_W'(strb.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg     <= {RESET_PC[ADDR_W-1:1], 1'b0};
      fetchAddr <= {RESET_PC[ADDR_W-1:2], 2'b00};
    end else if (strb.flush) begin
      pcReg     <= {redirPc[ADDR_W-1:1], 1'b0};
      fetchAddr <= {redirPc[ADDR_W-1:2], 2'b00};
    end else begin
      if (strb.advance) pcReg <= pcReg + (wide ? ADDR_W'(4) : ADDR_W'(2));
      if (strb.reqFire) fetchAddr <= fetchAddr + ADDR_W'(4);
    end
  end

  // Extraction of the instruction at pcReg from the head word(s)
  always_comb begin
    loHalf    = pcReg[1] ? slotData[rdPtr][WORD_W-1:HALF_W] : slotData[rdPtr][HALF_W-1:0];
    wide      = isWide(loHalf[1:0]);
    headOk    = 1'b0;
    headFault = 1'b0;
    rawData   = {{(WORD_W-HALF_W){1'b0}}, loHalf};
    if (count == '0) begin
      headOk = 1'b0;
    end else if (slotErr[rdPtr]) begin
      headOk    = 1'b1;
      headFault = 1'b1;
    end else if (!wide) begin
      headOk = 1'b1;
    end else if (!pcReg[1]) begin
      headOk  = 1'b1;
      rawData = slotData[rdPtr];
    end else if (count >= CNT_W'(2)) begin
      headOk    = 1'b1;
      headFault = slotErr[rdPtrNext];
      rawData   = {slotData[rdPtrNext][HALF_W-1:0], loHalf};
    end
  end

  assign popNeed = wide | pcReg[1];
  assign outData = headFault ? '0 : rawData;
  assign outPc   = pcReg;
  assign reqAddr = fetchAddr;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (count < CNT_W'(DEPTH) || strb.pop)); // R8

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (count != '0)); // R2

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (count == '0 || strb.push == 1'b0 && count == '0) || count == CNT_W'(1)); // R7

endmodule

// File: rtl/pf_align_ctrl.sv
`timescale 1ns/1ps
module pf_align_ctrl
  import pf_align_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             redirValid,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic             memRspErr,
  input  logic             insnReady,
  input  logic [CNT_W-1:0] count,
  input  logic             headOk,
  input  logic             headFault,
  input  logic             popNeed,
  output logic             memReqValid,
  output logic             insnValid,
  output pfStrobes_t       strb
);

  logic [CNT_W-1:0] inFlight, dropCnt;
  logic             reqHalt, outHalt;
  logic             rspKeep, fire;
  logic [CNT_W:0]   occupied;

  assign occupied    = {1'b0, count} + {1'b0, inFlight};
  assign memReqValid = !redirValid && !reqHalt && (occupied < (CNT_W+1)'(DEPTH));
  assign rspKeep     = memRspValid && (dropCnt == '0) && !redirValid;
  assign insnValid   = headOk && !outHalt && !redirValid;
  assign fire        = insnValid && insnReady;

  always_comb begin
    strb         = '0;
    strb.flush   = redirValid;
    strb.push    = rspKeep;
    strb.pop     = fire && popNeed;
    strb.advance = fire;
    strb.reqFire = memReqValid && memReqReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= '0;
      dropCnt  <= '0;
      reqHalt  <= 1'b0;
      outHalt  <= 1'b0;
    end else begin
      inFlight <= inFlight + CNT_W'(strb.reqFire) - CNT_W'(memRspValid);
      if (redirValid) begin
        dropCnt <= inFlight - CNT_W'(memRspValid);
        reqHalt <= 1'b0;
        outHalt <= 1'b0;
      end else begin
        if (memRspValid && dropCnt != '0) dropCnt <= dropCnt - CNT_W'(1);
        if (rspKeep && memRspErr) reqHalt <= 1'b1;
        if (fire && headFault) outHalt <= 1'b1;
      end
    end
  end

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    occupied <= (CNT_W+1)'(DEPTH)); // R8

  AST_HALT_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (fire && headFault) |=> (redirValid || (!insnValid && !memReqValid))); // R6

  AST_DROP_WITHIN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    dropCnt <= inFlight); // R7

endmodule

// File: rtl/pf_align_top.sv
`timescale 1ns/1ps
module pf_align_top
  import pf_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [WORD_W-1:0] memRspData,
  input  logic              memRspErr,
  input  logic              redirValid,
  input  logic [ADDR_W-1:0] redirPc,
  output logic              insnValid,
  input  logic              insnReady,
  output logic [ADDR_W-1:0] insnPc,
  output logic [WORD_W-1:0] insnData,
  output logic              insnFault
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  pfStrobes_t       strb;
  logic [CNT_W-1:0] count;
  logic             headOk, headFault, popNeed;

  pf_align_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .redirValid(redirValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .insnReady(insnReady),
    .count(count), .headOk(headOk), .headFault(headFault), .popNeed(popNeed),
    .memReqValid(memReqValid), .insnValid(insnValid), .strb(strb)
  );

  pf_align_dp #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .RESET_PC(RESET_PC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .redirPc(redirPc),
    .rspData(memRspData), .rspErr(memRspErr), .count(count), .reqAddr(memReqAddr),
    .headOk(headOk), .headFault(headFault), .popNeed(popNeed),
    .outPc(insnPc), .outData(insnData)
  );

  assign insnFault = headFault;

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[1:0] == 2'b00)); // R1

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (insnValid && insnFault) |-> (insnData == '0)); // R5

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (insnValid && !insnReady) |=> (redirValid ||
      (insnValid && $stable(insnPc) && $stable(insnData) && $stable(insnFault)))); // R9

  AST_PC_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    insnValid |-> (insnPc[0] == 1'b0)); // R2

endmodule

// File: tb/pf_align_top_tb_top.sv
`timescale 1ns/1ps
module pf_align_top_tb_top;
  localparam int ADDR_W = 32;
  localparam int DEPTH = 3;
  localparam logic [31:0] RESET_PC = 32'h0000_0102;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memReqValid, memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic memRspValid = 1'b0, memRspErr = 1'b0;
  logic [31:0] memRspData = '0;
  logic redirValid = 1'b0;
  logic [31:0] redirPc = '0;
  logic insnValid, insnReady = 1'b0, insnFault;
  logic [31:0] insnPc, insnData;

  always #5 clk = ~clk;

  pf_align_top #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .RESET_PC(RESET_PC)) dut_i (
    .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .memRspErr(memRspErr), .redirValid(redirValid), .redirPc(redirPc),
    .insnValid(insnValid), .insnReady(insnReady), .insnPc(insnPc),
    .insnData(insnData), .insnFault(insnFault)
  );

  int checks = 0;
  int errors = 0;
  int cycle = 0;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] data;
    logic        fault;
    int          tag;
  } expItem_t;

  expItem_t expQ[$];

  typedef struct {
    logic [31:0] addr;
    int          due;
  } busItem_t;

  busItem_t busQ[$];
  logic [31:0] reqExp = {RESET_PC[31:2], 2'b00};
  bit firstReq = 1'b1;
  string firstTag = "R10";

  function automatic string tagName(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      7: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] hwAt(input logic [31:0] a);
    if (a == 32'h0000_2FFE) return 16'h4001;
    if (a == 32'h0000_3FFE) return 16'h1233;
    return 16'(((a >> 1) * 32'd40503) + 32'd12345);
  endfunction

  function automatic bit isFaultWord(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w == 32'h0000_3000) || (w == 32'h0000_4000);
  endfunction

  // Expected instruction stream from the requirements (R2, R3, R4, R5)
  task automatic expectStream(input logic [31:0] start, input int maxN, input int firstTagNum, output bit hitFault);
    logic [31:0] pc;
    logic [15:0] lo;
    expItem_t it;
    pc = {start[31:1], 1'b0};
    hitFault = 1'b0;
    for (int n = 0; n < maxN; n++) begin
      lo = hwAt(pc);
      it.pc = pc;
      if (isFaultWord(pc) || (lo[1:0] == 2'b11 && isFaultWord(pc + 32'd2))) begin
        it.data = '0; it.fault = 1'b1; it.tag = 4;
        expQ.push_back(it);
        hitFault = 1'b1;
        break;
      end
      it.fault = 1'b0;
      if (lo[1:0] == 2'b11) begin
        it.data = {hwAt(pc + 32'd2), lo};
        it.tag = pc[1] ? 3 : 2;
        pc = pc + 32'd4;
      end else begin
        it.data = {16'h0, lo};
        it.tag = isFaultWord(pc + 32'd2) ? 4 : 2;
        pc = pc + 32'd2;
      end
      if (n == 0 && firstTagNum != 0) it.tag = firstTagNum;
      expQ.push_back(it);
    end
  endtask

  // Monitor: drives ready, compares issued instructions, checks hold (R9)
  initial begin : monitor
    bit holdPend;
    logic [31:0] hPc, hData;
    logic hFault;
    expItem_t e;
    holdPend = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (!rstN) begin
        insnReady = 1'b0;
        holdPend = 1'b0;
      end else begin
        if (holdPend) begin
          chk(insnValid && insnPc == hPc && insnData == hData && insnFault == hFault,
              "R9", insnPc, hPc);
          holdPend = 1'b0;
        end
        insnReady = (cycle % 7 != 3) && (cycle % 11 != 5) && (expQ.size() > 0);
        if (insnValid && insnReady) begin
          e = expQ.pop_front();
          chk(insnPc == e.pc, tagName(e.tag), insnPc, e.pc);
          chk(insnData == e.data, e.fault ? "R5" : tagName(e.tag), insnData, e.data);
          chk(insnFault == e.fault, e.fault ? "R4" : tagName(e.tag), 32'(insnFault), 32'(e.fault));
        end else if (insnValid && expQ.size() > 0) begin
          holdPend = 1'b1;
          hPc = insnPc; hData = insnData; hFault = insnFault;
        end
      end
    end
  end

  // Bus responder with fixed latency, request address tracking (R1, R7, R8, R10)
  initial begin : responder
    busItem_t b;
    forever begin
      @(negedge clk); #4;
      cycle++;
      memRspValid = 1'b0;
      memRspErr = 1'b0;
      memRspData = '0;
      if (rstN) begin
        if (busQ.size() > 0 && busQ[0].due <= cycle) begin
          b = busQ.pop_front();
          memRspValid = 1'b1;
          memRspErr = isFaultWord(b.addr);
          memRspData = memRspErr ? 32'hDEAD_BEEF : {hwAt(b.addr + 32'd2), hwAt(b.addr)};
        end
        memReqReady = (cycle % 5 != 2);
        if (memReqValid && memReqReady) begin
          chk(memReqAddr == reqExp, firstReq ? firstTag : "R1", memReqAddr, reqExp);
          chk(memReqAddr[1:0] == 2'b00, "R1", memReqAddr, {memReqAddr[31:2], 2'b00});
          firstReq = 1'b0;
          reqExp = reqExp + 32'd4;
          b.addr = memReqAddr;
          b.due = cycle + LAT;
          busQ.push_back(b);
          chk(busQ.size() + (memRspValid ? 1 : 0) <= DEPTH, "R8", 32'(busQ.size()), 32'(DEPTH));
        end
      end
    end
  end

  task automatic waitEmpty();
    do begin
      @(negedge clk); #2;
    end while (expQ.size() > 0);
  endtask

  task automatic haltCheck();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #2;
      chk(!insnValid, "R6", 32'(insnValid), 32'd0);
      chk(!memReqValid, "R6", 32'(memReqValid), 32'd0);
    end
  endtask

  task automatic phase(input logic [31:0] start, input int n);
    bit f;
    @(negedge clk); #3;
    redirValid = 1'b1;
    redirPc = start;
    reqExp = {start[31:2], 2'b00};
    firstReq = 1'b1;
    firstTag = "R7";
    expectStream(start, n, start[1] ? 7 : 0, f);
    @(negedge clk); #3;
    redirValid = 1'b0;
    waitEmpty();
    if (f) haltCheck();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    bit f;
    rstN = 1'b0;
    repeat (4) begin
      @(negedge clk); #2;
      chk(!insnValid, "R10", 32'(insnValid), 32'd0);
    end
    #1;
    rstN = 1'b1;
    expectStream(RESET_PC, 20, 10, f);
    waitEmpty();
    phase(32'h0000_2000, 30);
    phase(32'h0000_2F80, 200);
    phase(32'h0000_2FFE, 10);
    phase(32'h0000_3FFE, 10);
    phase(32'h0000_4000, 10);
    phase(32'h0000_3002, 10);
    phase(32'h0000_1006, 40);
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule